// File: doc/BRIEF.md
# Watchdog Frequency Self-Recovery Controller

This block protects a system against a hang after software changes the clock frequency at run time. Software writes a new frequency code and pulses a change strobe. If a timeout of N seconds has been selected beforehand, the block counts seconds ticks until software confirms the setting by writing the timeout field back to zero. If that confirmation does not arrive, the block pulls the system reset low for a fixed number of reference-clock cycles and raises an alarm bit.

The first expiry only resets the system. Each later expiry also drops the frequency back to a fallback code. The fallback is either the hardware strap code or the software code that was in force before the most recent change. The block keeps a two-entry history of software codes for this purpose.

A shared board pin is either a power-down input or an open-drain reset output, chosen by a mode bit. The seconds tick comes from outside the block, and the reset pulse width is a parameter, so a simulation can use short values.

Top module: `wdr_top`

## Requirements
- R1: After reset, `freq_out` equals `strap_freq`, `alarm` is 0, `rst_pull` is 0 and `pwr_down` is 0 while the pin input is high.
- R2: A `freq_chg` strobe loads `sw_freq` onto `freq_out` at the next clock edge, whatever the timeout field holds. With the field at 0000 no watchdog is armed, and no number of ticks raises `alarm` or a reset pulse.
- R3: The timeout field value N (1 to 15) is a count of seconds. After a strobe armed with a nonzero field, expiry occurs on the N-th `sec_tick` and on no earlier tick.
- R4: On the first expiry after arming, the block starts a reset pulse and sets `alarm` to 1, and `freq_out` keeps its value. The counter then restarts.
- R5: On the second expiry and every later one, the block starts a reset pulse, sets `alarm` to 1 and loads the fallback code onto `freq_out`. This repeats every N ticks until the field is cleared.
- R6: With `revert_sel` = 0 the fallback is `strap_freq`. With `revert_sel` = 1 it is the `sw_freq` value captured by the strobe before the most recent one. If only one strobe has occurred, it is `strap_freq`.
- R7: A reset pulse lasts exactly PULSE_CYC clock cycles. It begins in the cycle after the expiring tick edge.
- R8: With `pin_mode` = 1 the pin is a power-down input: `pwr_down` = NOT `pin_in_n` and `rst_pull` stays 0 even during a pulse. With `pin_mode` = 0, `rst_pull` is 1 exactly during a pulse and `pwr_down` is 0.
- R9: Writing the field to 0000 stops the timer and clears `alarm` at the next edge, and `freq_out` keeps its value. Later ticks cause no pulse.
- R10: A new strobe or a change of the timeout field restarts the second count from zero. When a strobe coincides with an expiring tick, the strobe wins: no pulse starts, no alarm is set, and the new code is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| freq_chg | input | 1 | One-cycle strobe: software wrote a new frequency code |
| sw_freq | input | FREQ_W | Software frequency code, sampled on `freq_chg` |
| strap_freq | input | FREQ_W | Hardware strap frequency code |
| wd_sel | input | 4 | Timeout field: 0 = off, N = N seconds |
| revert_sel | input | 1 | Fallback choice: 0 = strap, 1 = previous software code |
| pin_mode | input | 1 | Shared pin role: 1 = power-down input, 0 = reset output |
| pin_in_n | input | 1 | Level seen on the shared pin (active low power-down) |
| rst_pull | output | 1 | 1 = drive the shared pin low (open-drain reset) |
| pwr_down | output | 1 | Power-down request decoded from the pin |
| alarm | output | 1 | Watchdog alarm status |
| freq_out | output | FREQ_W | Frequency code to apply |

## Verification
A new frequency strobe and an expiring seconds tick can land in the same cycle. In that case the restart has to override the expiry. The bench arms a two-second timeout, lets one tick pass, and then raises `freq_chg` and `sec_tick` together. It expects no pulse, no alarm and the new code at the next sample. It then expects the count to start again from zero, so expiry must come on the second later tick, not the first. A field rewrite and a pending tick are treated the same way: the bench shortens the field from three to two after two ticks, and an expiry on the very next tick counts as a failure.

// File: rtl/wdr_pkg.sv
// Package wdr_pkg
// Shared width and type of the watchdog timeout field.
package wdr_pkg;
    localparam int TO_W = 4;
    typedef logic [TO_W-1:0] to_sel_t;
endpackage

// File: rtl/wdr_timer.sv
// Module wdr_timer
// Counts seconds ticks after a frequency change and flags each expiry.
// It also reports whether the watchdog has already expired once since it
// was armed. Assumes sec_tick and freq_chg are single-cycle pulses.
module wdr_timer
    import wdr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sec_tick,
    input  logic    freq_chg,
    input  to_sel_t wd_sel,
    output logic    expire,
    output logic    revert
);
    logic    armed;
    logic    second;
    to_sel_t cnt;
    to_sel_t sel_q;
    logic    restart;
    logic    field_off;
    to_sel_t cnt_inc;

    // Decode restart conditions and the expiring tick.
    always_comb begin
        field_off = (wd_sel == '0);
        restart   = freq_chg || (wd_sel != sel_q);
        cnt_inc   = cnt + 1'b1;
        expire    = armed && sec_tick && !field_off && !restart && (cnt_inc == wd_sel);
        revert    = expire && second;
    end

    // Arm, count seconds, restart and note the first expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            second <= 1'b0;
            cnt    <= '0;
            sel_q  <= '0;
        end else begin
            sel_q <= wd_sel;
            if (field_off) begin
                armed  <= 1'b0;
                second <= 1'b0;
                cnt    <= '0;
            end else if (freq_chg) begin
                armed  <= 1'b1;
                second <= 1'b0;
                cnt    <= '0;
            end else if (restart) begin
                cnt <= '0;
            end else if (expire) begin
                cnt    <= '0;
                second <= 1'b1;
            end else if (armed && sec_tick) begin
                cnt <= cnt_inc;
            end
        end
    end

    assert_cnt_below_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (wd_sel == sel_q)) |-> (cnt < wd_sel));

    assert_disarm_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_sel == '0) |=> !armed);
endmodule

// File: rtl/wdr_pulse.sv
// Module wdr_pulse
// Stretches a one-cycle expiry flag into a reset pulse of PULSE_CYC cycles.
// A new trigger during a pulse reloads the full width.
module wdr_pulse #(
    parameter int PULSE_CYC = 42000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic active
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] LOAD = PW'(PULSE_CYC);

    logic [PW-1:0] cnt;

    // Report the pulse while the down-counter is nonzero.
    always_comb active = (cnt != '0);

    // Load on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (trigger)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assert_pulse_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (cnt == LOAD));

    assert_pulse_counts_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !trigger) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wdr_freq_hist.sv
// Module wdr_freq_hist
// Holds the applied frequency code and the last two software codes.
// A change strobe applies the new code. A revert applies the fallback.
// Assumes strap_freq is stable while rst_n is low.
module wdr_freq_hist #(
    parameter int FREQ_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freq_chg,
    input  logic              revert,
    input  logic              revert_sel,
    input  logic [FREQ_W-1:0] sw_freq,
    input  logic [FREQ_W-1:0] strap_freq,
    output logic [FREQ_W-1:0] freq_out
);
    logic [FREQ_W-1:0] cur_sw;
    logic [FREQ_W-1:0] prev_sw;
    logic [FREQ_W-1:0] fallback;

    // Choose the fallback code from the revert bit.
    always_comb fallback = revert_sel ? prev_sw : strap_freq;

    // Shift the history on a strobe and update the applied code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sw   <= strap_freq;
            prev_sw  <= strap_freq;
            freq_out <= strap_freq;
        end else if (freq_chg) begin
            prev_sw  <= cur_sw;
            cur_sw   <= sw_freq;
            freq_out <= sw_freq;
        end else if (revert) begin
            freq_out <= fallback;
        end
    end

    assert_applies_sw_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(freq_chg)) |-> (freq_out == $past(sw_freq)));

    assert_history_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(freq_chg)) |-> (prev_sw == $past(cur_sw)));
endmodule

// File: rtl/wdr_top.sv
// Module wdr_top
// Watchdog frequency self-recovery controller. Links the seconds timer,
// the reset pulse stretcher and the frequency history. Holds the alarm bit
// and sets the role of the shared pin. The seconds tick comes from outside.
module wdr_top
    import wdr_pkg::*;
#(
    parameter int FREQ_W    = 4,
    parameter int PULSE_CYC = 42000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              freq_chg,
    input  logic [FREQ_W-1:0] sw_freq,
    input  logic [FREQ_W-1:0] strap_freq,
    input  logic [TO_W-1:0]   wd_sel,
    input  logic              revert_sel,
    input  logic              pin_mode,
    input  logic              pin_in_n,
    output logic              rst_pull,
    output logic              pwr_down,
    output logic              alarm,
    output logic [FREQ_W-1:0] freq_out
);
    logic expire;
    logic revert;
    logic pulse_on;

    wdr_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .freq_chg (freq_chg),
        .wd_sel   (wd_sel),
        .expire   (expire),
        .revert   (revert)
    );

    wdr_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (expire),
        .active  (pulse_on)
    );

    wdr_freq_hist #(.FREQ_W(FREQ_W)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq_chg   (freq_chg),
        .revert     (revert),
        .revert_sel (revert_sel),
        .sw_freq    (sw_freq),
        .strap_freq (strap_freq),
        .freq_out   (freq_out)
    );

    // Alarm sets on any expiry and clears when the field returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm <= 1'b0;
        else if (wd_sel == '0)
            alarm <= 1'b0;
        else if (expire)
            alarm <= 1'b1;
    end

    // Shared pin: reset output drive or power-down input decode.
    always_comb begin
        rst_pull = !pin_mode && pulse_on;
        pwr_down = pin_mode && !pin_in_n;
    end

    assert_revert_after_alarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(freq_chg) && (freq_out != $past(freq_out))) |-> $past(alarm));

    assert_alarm_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> pulse_on);
endmodule

// File: tb/tb_wdr_top.sv
// Bench tb_wdr_top: sweeps timeout values 1..4, both fallback modes, the
// pin roles, and the strobe/tick and field/tick collisions.
module tb_wdr_top;
    localparam int FW  = 4;
    localparam int PC  = 5;
    localparam logic [FW-1:0] STRAP = 4'h3;

    logic clk = 1'b0;
    logic rst_n, sec_tick, freq_chg, revert_sel, pin_mode, pin_in_n;
    logic [FW-1:0] sw_freq;
    logic [3:0] wd_sel;
    logic rst_pull, pwr_down, alarm;
    logic [FW-1:0] freq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wdr_top #(.FREQ_W(FW), .PULSE_CYC(PC)) dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .freq_chg(freq_chg),
        .sw_freq(sw_freq), .strap_freq(STRAP), .wd_sel(wd_sel),
        .revert_sel(revert_sel), .pin_mode(pin_mode), .pin_in_n(pin_in_n),
        .rst_pull(rst_pull), .pwr_down(pwr_down), .alarm(alarm), .freq_out(freq_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic chg(input logic [FW-1:0] code);
        sw_freq  = code;
        freq_chg = 1'b1;
        @(negedge clk);
        freq_chg = 1'b0;
    endtask

    task automatic pulse_len(output int n);
        n = 0;
        while (rst_pull && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int len;
        int bad;
        logic [FW-1:0] fb;
        rst_n = 1'b0; sec_tick = 1'b0; freq_chg = 1'b0; sw_freq = '0;
        wd_sel = '0; revert_sel = 1'b0; pin_mode = 1'b1; pin_in_n = 1'b1;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 freq", freq_out, STRAP);
        chk("R1 alarm", alarm, 0);
        chk("R1 rst_pull", rst_pull, 0);
        chk("R1 pwr_down", pwr_down, 0);

        // R2 change with field off: applied, never armed
        chg(4'hD);
        chk("R2 freq", freq_out, 4'hD);
        pin_mode = 1'b0;
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            tick();
            if (alarm || rst_pull) bad++;
            idle(2);
        end
        chk("R2 no arm", bad, 0);

        // Sweep timeout values and fallback modes (R3..R7, R9)
        for (int t = 1; t <= 4; t++) begin
            revert_sel = t[0];
            wd_sel = '0;
            idle(2);
            chg(4'(t + 4));
            chk("R2 freq B", freq_out, t + 4);
            wd_sel = 4'(t);
            idle(2);
            chg(4'(t + 8));
            chk("R2 freq A", freq_out, t + 8);
            fb = revert_sel ? 4'(t + 4) : STRAP;
            bad = 0;
            for (int i = 1; i < t; i++) begin
                tick();
                if (alarm || rst_pull) bad++;
                idle(8);
            end
            chk("R3 early expiry", bad, 0);
            tick();
            chk("R4 alarm", alarm, 1);
            chk("R4 freq kept", freq_out, t + 8);
            pulse_len(len);
            chk("R7 width", len, PC);
            idle(8);
            for (int i = 1; i < t; i++) begin tick(); idle(8); end
            tick();
            chk("R5 pulse", rst_pull, 1);
            chk("R5 alarm", alarm, 1);
            chk("R6 fallback", freq_out, fb);
            idle(8);
            for (int i = 1; i < t; i++) begin tick(); idle(8); end
            tick();
            chk("R5 repeat pulse", rst_pull, 1);
            chk("R5 repeat freq", freq_out, fb);
            idle(8);
            wd_sel = '0;
            idle(1);
            chk("R9 alarm clear", alarm, 0);
            chk("R9 freq kept", freq_out, fb);
            bad = 0;
            for (int i = 0; i < 16; i++) begin
                tick();
                if (rst_pull) bad++;
                idle(2);
            end
            chk("R9 stopped", bad, 0);
        end

        // R6 single strobe with revert_sel=1 falls back to strap
        revert_sel = 1'b1;
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        wd_sel = 4'd1; idle(2);
        chg(4'hA);
        tick(); idle(8);
        tick();
        chk("R6 single history", freq_out, STRAP);
        wd_sel = '0; idle(8);

        // R10 strobe collides with expiring tick
        revert_sel = 1'b0;
        wd_sel = 4'd2; idle(2);
        chg(4'hC);
        tick(); idle(8);
        sw_freq = 4'hE; freq_chg = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        freq_chg = 1'b0; sec_tick = 1'b0;
        chk("R10 collide no pulse", rst_pull, 0);
        chk("R10 collide no alarm", alarm, 0);
        chk("R10 collide freq", freq_out, 4'hE);
        idle(8);
        tick();
        chk("R10 restart count", rst_pull, 0);
        idle(8);
        tick();
        chk("R10 expiry after restart", rst_pull, 1);
        chk("R10 first expiry keeps freq", freq_out, 4'hE);
        wd_sel = '0; idle(8);

        // R10 field change restarts the count
        wd_sel = 4'd3; idle(2);
        chg(4'h6);
        tick(); idle(8);
        tick(); idle(8);
        wd_sel = 4'd2; idle(2);
        tick();
        chk("R10 field restart", rst_pull, 0);
        idle(8);
        tick();
        chk("R10 field expiry", rst_pull, 1);
        wd_sel = '0; idle(8);

        // R8 pin roles
        pin_mode = 1'b1;
        wd_sel = 4'd1; idle(2);
        chg(4'h7);
        tick();
        chk("R8 input mode alarm", alarm, 1);
        bad = 0;
        for (int i = 0; i < PC; i++) begin
            if (rst_pull) bad++;
            @(negedge clk);
        end
        chk("R8 no drive in input mode", bad, 0);
        pin_in_n = 1'b0; #1;
        chk("R8 power-down decode", pwr_down, 1);
        pin_in_n = 1'b1; #1;
        chk("R8 power-down idle", pwr_down, 0);
        pin_mode = 1'b0; pin_in_n = 1'b0; #1;
        chk("R8 output mode ignores pin", pwr_down, 0);
        pin_in_n = 1'b1;
        wd_sel = '0; idle(4);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule